// File: doc/BRIEF.md
# Split-Word Strobe Code Receiver

This block receives a 6-bit setting word over a narrow parallel link: three data lines and a single strobe. The word arrives in two halves. A falling strobe edge takes the data lines as the low half. The following rising edge takes them as the high half and completes the word. Every input line passes through a counter-based deglitch filter. The strobe then passes through a further delay line, so a controller may switch data and strobe in the same instant with no setup margin.

The received word is held until the next complete transfer. A reset returns it to a nonzero default, and so does a low level on the enable input. Beside the word, the block drives a registered magnitude code for a downstream current DAC. The magnitude runs opposite to the word: the lowest word gives full scale and the highest word gives zero.

Top module: `strobe_word_rx`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises, word_q reads the default 46 and mag_q reads 17. The filtered strobe starts at the idle level 1, so no edge is seen at start-up.
- R2: A falling edge of the filtered, delayed strobe stores data_in as word bits [2:0] in a staging register only. word_q and mag_q keep their old values until the matching rising edge.
- R3: A rising edge of the filtered, delayed strobe loads word_q with {data_in filtered as bits [5:3], staged bits [2:0]}.
- R4: word_q changes only after a rising-edge capture, a reset or a low enable.
- R5: Each input line is accepted at a new level only after it holds that level for FILT_CYC consecutive clock samples. With the default of 4, a 3-cycle strobe pulse captures nothing.
- R6: mag_q equals 63 minus word_q, taken from the word one clock earlier.
- R7: With en low at a clock edge, the word, the staging register, the filters and the strobe path return to their reset values. word_q becomes 46 and mag_q becomes 17.
- R8: The strobe path adds STB_DLY cycles beyond the data filter, so data and strobe may change in the same cycle. With defaults, a strobe rise that is first sampled at clock edge 1 updates word_q at edge 9 and mag_q at edge 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low acts as a synchronous reset to the default word |
| data_in | input | 3 | Half-word data lines |
| strobe_in | input | 1 | Capture strobe, idle high |
| word_q | output | 6 | Current received word |
| mag_q | output | 6 | DAC magnitude code, 63 minus the word |

## Verification
Suppose the staging register or the filter counters hold a wrong value. The ports do not show it at the falling edge. It shows only at the next completed rising-edge capture, FILT_CYC+STB_DLY+1 cycles after the strobe rises, as a wrong low half or a capture that happens at the wrong edge. A wrong magnitude shows one cycle after any word change. The bench therefore checks complete transfers, the word held between the two halves, the exact edge on which each output changes, short strobe pulses, and a return to default when enable goes low.

// File: rtl/strobe_word_pkg.sv
package strobe_word_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_RISE = 2'd2
   } stb_edge_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/deglitch_bit.sv
module deglitch_bit #(
   parameter int unsigned FILT_CYC = 4,
   parameter bit          RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic dout
);
   localparam int unsigned CNT_W = strobe_word_pkg::cnt_width(FILT_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= RST_VAL;
         cnt   <= '0;
      end else if (clr) begin
         level <= RST_VAL;
         cnt   <= '0;
      end else if (din == level) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         level <= din;
         cnt   <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign dout = level;
endmodule

// File: rtl/strobe_delay.sv
module strobe_delay #(
   parameter int unsigned DLY     = 4,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic dout
);
   generate
      if (DLY == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [DLY-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr <= {DLY{RST_VAL}};
            else if (clr)    sr <= {DLY{RST_VAL}};
            else if (DLY == 1) sr <= din;
            else             sr <= {sr[DLY-2:0], din} [DLY-1:0];
         end
         assign dout = sr[DLY-1];
      end
   endgenerate
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge
   import strobe_word_pkg::*;
#(
   parameter bit IDLE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      stb,
   output stb_edge_t edge_o
);
   logic last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last <= IDLE;
      else if (clr) last <= IDLE;
      else          last <= stb;
   end

   always_comb begin
      edge_o = EDGE_NONE;
      if (last && !stb)      edge_o = EDGE_FALL;
      else if (!last && stb) edge_o = EDGE_RISE;
   end
endmodule

// File: rtl/word_assembler.sv
module word_assembler
   import strobe_word_pkg::*;
#(
   parameter int unsigned HALF_W       = 3,
   parameter int unsigned DEFAULT_WORD = 46,
   localparam int unsigned WORD_W      = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  stb_edge_t         edge_i,
   input  logic [HALF_W-1:0] data_i,
   output logic [WORD_W-1:0] word_o,
   output logic [WORD_W-1:0] mag_o
);
   localparam logic [WORD_W-1:0] DEF  = WORD_W'(DEFAULT_WORD);
   localparam logic [WORD_W-1:0] FULL = {WORD_W{1'b1}};

   logic [HALF_W-1:0] lo_stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_stage <= DEF[HALF_W-1:0];
         word_o   <= DEF;
         mag_o    <= FULL - DEF;
      end else if (clr) begin
         lo_stage <= DEF[HALF_W-1:0];
         word_o   <= DEF;
         mag_o    <= FULL - DEF;
      end else begin
         mag_o <= FULL - word_o;
         unique case (edge_i)
            EDGE_FALL: lo_stage <= data_i;
            EDGE_RISE: word_o   <= {data_i, lo_stage};
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/strobe_word_rx.sv
module strobe_word_rx
   import strobe_word_pkg::*;
#(
   parameter int unsigned HALF_W       = 3,
   parameter int unsigned FILT_CYC     = 4,
   parameter int unsigned STB_DLY      = 4,
   parameter int unsigned DEFAULT_WORD = 46,
   localparam int unsigned WORD_W      = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HALF_W-1:0] data_in,
   input  logic              strobe_in,
   output logic [WORD_W-1:0] word_q,
   output logic [WORD_W-1:0] mag_q
);
   generate
      if (HALF_W < 1) begin : g_bad_half
         $error("HALF_W must be at least 1");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("FILT_CYC must be at least 1");
      end
      if (DEFAULT_WORD >= (1 << WORD_W)) begin : g_bad_def
         $error("DEFAULT_WORD does not fit the word");
      end
   endgenerate

   logic              clr;
   logic [HALF_W-1:0] data_f;
   logic              stb_filt;
   logic              stb_dly;
   stb_edge_t         edge_kind;
   logic              stb_rise;

   assign clr = ~en;

   generate
      for (genvar i = 0; i < HALF_W; i++) begin : g_data_filt
         deglitch_bit #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b0)) u_flt (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .din(data_in[i]), .dout(data_f[i])
         );
      end
   endgenerate

   deglitch_bit #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_stb_flt (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .din(strobe_in), .dout(stb_filt)
   );

   strobe_delay #(.DLY(STB_DLY), .RST_VAL(1'b1)) u_stb_dly (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .din(stb_filt), .dout(stb_dly)
   );

   strobe_edge #(.IDLE(1'b1)) u_edge (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .stb(stb_dly), .edge_o(edge_kind)
   );

   assign stb_rise = (edge_kind == EDGE_RISE);

   word_assembler #(.HALF_W(HALF_W), .DEFAULT_WORD(DEFAULT_WORD)) u_asm (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .edge_i(edge_kind), .data_i(data_f),
      .word_o(word_q), .mag_o(mag_q)
   );
endmodule

// File: rtl/strobe_word_rx_chk.sv
module strobe_word_rx_chk #(
   parameter int unsigned WORD_W       = 6,
   parameter int unsigned DEFAULT_WORD = 46
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              strobe_in,
   input logic              stb_filt,
   input logic              stb_rise,
   input logic [WORD_W-1:0] word_q,
   input logic [WORD_W-1:0] mag_q
);
   localparam logic [WORD_W-1:0] FULL = {WORD_W{1'b1}};
   localparam logic [WORD_W-1:0] DEF  = WORD_W'(DEFAULT_WORD);

   p_mag_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (mag_q == FULL - $past(word_q)))
      else $error("mag_q not inverse of previous word");

   p_enable_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (word_q == DEF && mag_q == FULL - DEF))
      else $error("enable low did not restore default");

   p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !stb_rise) |=> $stable(word_q))
      else $error("word changed without rising capture");

   p_filter_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$stable(stb_filt)) |-> (stb_filt == $past(strobe_in)))
      else $error("filtered strobe took a level the input did not hold");
endmodule

bind strobe_word_rx strobe_word_rx_chk #(
   .WORD_W(WORD_W), .DEFAULT_WORD(DEFAULT_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .strobe_in(strobe_in),
   .stb_filt(stb_filt), .stb_rise(stb_rise),
   .word_q(word_q), .mag_q(mag_q)
);

// File: tb/sim_strobe_word_rx.sv
module sim_strobe_word_rx;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 12;

   typedef struct packed {
      logic [5:0] w;
      logic [5:0] m;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{6'd0,  6'd63}, '{6'd63, 6'd0},  '{6'd21, 6'd42},
      '{6'd42, 6'd21}, '{6'd5,  6'd58}, '{6'd46, 6'd17}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b1;
   logic [2:0] data_in = 3'd0;
   logic       strobe_in = 1'b1;
   logic [5:0] word_q, mag_q;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strobe_word_rx u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .data_in(data_in),
      .strobe_in(strobe_in), .word_q(word_q), .mag_q(mag_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [5:0] w);
      @(negedge clk);
      data_in = w[2:0]; strobe_in = 1'b0;
      wait_n(SETTLE);
      data_in = w[5:3]; strobe_in = 1'b1;
      wait_n(SETTLE);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      wait_n(3);
      chk("R1 word in reset", word_q, 46);
      chk("R1 mag in reset", mag_q, 17);
      rst_n = 1'b1;
      wait_n(SETTLE);
      chk("R1 word after reset", word_q, 46);
      chk("R1 mag after reset", mag_q, 17);

      // R3 R6: table of complete transfers
      for (int i = 0; i < 6; i++) begin
         send(VECS[i].w);
         chk("R3 word", word_q, VECS[i].w);
         chk("R6 mag", mag_q, VECS[i].m);
      end

      // R2: after falling edge only, word is unchanged
      @(negedge clk);
      data_in = 3'd2; strobe_in = 1'b0;
      wait_n(SETTLE);
      chk("R2 word held after low half", word_q, 46);
      chk("R2 mag held after low half", mag_q, 17);

      // R8: latency of rising capture, data and strobe switched together
      data_in = 3'd7; strobe_in = 1'b1;
      wait_n(8);
      chk("R8 word before edge 9", word_q, 46);
      wait_n(1);
      chk("R8 word at edge 9", word_q, 58);
      chk("R6 mag still old at edge 9", mag_q, 17);
      wait_n(1);
      chk("R6 mag at edge 10", mag_q, 5);

      // R5: 3-cycle strobe pulse is rejected
      data_in = 3'd1; strobe_in = 1'b0;
      wait_n(3);
      data_in = 3'd0; strobe_in = 1'b1;
      wait_n(SETTLE);
      chk("R5 word after short pulse", word_q, 58);
      // a real transfer afterwards proves staging untouched by the pulse
      @(negedge clk);
      data_in = 3'd3; strobe_in = 1'b0;
      wait_n(SETTLE);
      data_in = 3'd1; strobe_in = 1'b1;
      wait_n(3);
      data_in = 3'd1; strobe_in = 1'b1;
      wait_n(SETTLE);
      chk("R5 R4 word after full transfer", word_q, 11);

      // R7: enable low restores default
      en = 1'b0;
      wait_n(2);
      chk("R7 word with en low", word_q, 46);
      chk("R7 mag with en low", mag_q, 17);
      en = 1'b1;
      send(6'd33);
      chk("R7 word after re-enable", word_q, 33);
      chk("R4 mag after re-enable", mag_q, 30);

      finish_run();
   end
endmodule